// File: doc/BRIEF.md
# Two-Channel Amplifier Protection and Power-State Supervisor

This block decides when each output stage of a two-channel speaker amplifier may switch. It combines a hardware shutdown pin, a software shutdown bit and one enable bit per channel with the protection inputs: one over-current detector per channel and a raw over-temperature comparator. From these it drives one output-stage enable per channel and a reduced-duty-cycle request per channel. It also holds the sticky status flags that software reads and clears, and it issues the reset pulse for the register file.

An over-current event is latched in two places. One is a status flag that software clears by writing a zero. The other is a degraded-mode request that stays set until the part goes through a shutdown, either through the pin or through the software bit. Over-temperature is deglitched on a sample tick. While the condition lasts it blocks both stages, and the stages come back by themselves when it ends. Its flag stays latched until software clears it. Whenever the part leaves shutdown, the stages stay off until a start-up delay has elapsed.

Top module: `amp_supervisor`

## Requirements
- R1: After reset, and while the synchronized pin is low, every output is 0: stage enables, low-duty requests, fault flags, thermal flag and the register-reset pulse.
- R2: The shutdown pin (active low) passes through a two-flop synchronizer. reg_rst_o is high for exactly one clock, starting two edges after the pin falls. The same falling edge clears the fault flags and the thermal flag one clock later.
- R3: The device is active when the synchronized pin is high and sw_shdn_i is 0. Stage enables stay 0 until STARTUP_CYC clock edges have passed since the device became active. Leaving the active state restarts the count from zero.
- R4: Once start-up is complete, stage_en_o[c] follows ch_en_i[c] with no delay. Clearing one channel's enable affects only that channel.
- R5: oc_det_i[c] high at a clock edge while the device is active sets fault_flag_o[c] and low_duty_o[c] after that edge. The stage enable is left as it was.
- R6: low_duty_o[c] stays set until the device becomes inactive, through the pin or through software shutdown. Clearing the fault flag does not clear it.
- R7: A write (flag_wr_i high) clears fault_flag_o[c] when bit c of wr_fault_i is 0 and leaves it unchanged when that bit is 1.
- R8: The over-temperature condition starts only after therm_raw_i has been seen high on THERM_TICKS consecutive tick_i cycles (16 by default). A tick with the raw input low restarts the count. Cycles without a tick are not counted.
- R9: While over-temperature holds, both stage enables are 0. They come back when a tick sees the raw input low. therm_flag_o is set one clock after the condition starts and stays set after the condition ends.
- R10: A write with wr_therm_i = 0 clears therm_flag_o, and a write with wr_therm_i = 1 leaves it unchanged.
- R11: Software shutdown clears the low-duty requests and turns both stages off without issuing a register-reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shdn_pin_ni | input | 1 | Asynchronous hardware shutdown pin, low = shut down |
| sw_shdn_i | input | 1 | Software shutdown bit |
| ch_en_i | input | NCH | Per-channel stage enable bits |
| oc_det_i | input | NCH | Per-channel over-current detector flags |
| therm_raw_i | input | 1 | Raw over-temperature comparator |
| tick_i | input | 1 | Sample strobe for the thermal deglitch |
| flag_wr_i | input | 1 | Status register write strobe |
| wr_fault_i | input | NCH | Written fault bits (0 clears) |
| wr_therm_i | input | 1 | Written thermal bit (0 clears) |
| stage_en_o | output | NCH | Output-stage enables |
| low_duty_o | output | NCH | Reduced-duty-cycle mode requests |
| fault_flag_o | output | NCH | Sticky over-current flags |
| therm_flag_o | output | 1 | Sticky thermal flag |
| reg_rst_o | output | 1 | One-clock register-file reset pulse |

## Verification
Two states are hard to reach from the ports. The first is a channel left in degraded mode with its fault flag already cleared. The bench gets there by pulsing the over-current input, writing the flag to zero, and only then toggling software shutdown, so that it can show the two latches clear on different events. The second is an over-temperature run that is broken one tick short. The bench holds the raw comparator through long runs that are cut by a single low tick, and through runs with no ticks at all, and confirms that the enables never drop in either case.

// File: rtl/amp_sup_pkg.sv
package amp_sup_pkg;
  localparam int unsigned NCH_DEF       = 2;
  localparam int unsigned THERM_DEF     = 16;
  localparam int unsigned STARTUP_DEF   = 200_000; // 4 ms at 50 MHz

  typedef enum logic [1:0] {
    PWR_OFF,
    PWR_WAIT,
    PWR_ON
  } pwr_state_e;
endpackage

// File: rtl/amp_pin_sync.sv
module amp_pin_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pin_o  = s2_q;
  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/amp_therm_deglitch.sv
module amp_therm_deglitch #(
  parameter int unsigned TICKS = 16,
  localparam int unsigned CW   = $clog2(TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic raw_i,
  output logic hot_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_i) begin
      if (!raw_i)                    cnt_q <= '0;
      else if (cnt_q != CW'(TICKS))  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hot_o = (cnt_q == CW'(TICKS));
endmodule

// File: rtl/amp_startup_timer.sv
module amp_startup_timer
  import amp_sup_pkg::*;
#(
  parameter int unsigned CYC = STARTUP_DEF,
  localparam int unsigned CW = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic ready_o
);
  pwr_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PWR_OFF;
      cnt_q <= '0;
    end else if (!active_i) begin
      st_q  <= PWR_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        PWR_OFF: begin
          cnt_q <= CW'(1);
          st_q  <= (CYC <= 1) ? PWR_ON : PWR_WAIT;
        end
        PWR_WAIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(CYC - 1)) st_q <= PWR_ON;
        end
        default: st_q <= PWR_ON;
      endcase
    end
  end

  assign ready_o = (st_q == PWR_ON);
endmodule

// File: rtl/amp_chan_fault.sv
module amp_chan_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic active_i,
  input  logic oc_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic flag_o,
  output logic low_duty_o
);
  logic set;
  assign set = active_i & oc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_o <= 1'b0;
    else if (!pin_i)            flag_o <= 1'b0;
    else if (set)               flag_o <= 1'b1;
    else if (wr_i && !wr_bit_i) flag_o <= 1'b0;
  end

  // degraded mode leaves only through a shutdown cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_duty_o <= 1'b0;
    else if (!active_i) low_duty_o <= 1'b0;
    else if (set)      low_duty_o <= 1'b1;
  end
endmodule

// File: rtl/amp_supervisor.sv
module amp_supervisor
  import amp_sup_pkg::*;
#(
  parameter int unsigned NCH         = NCH_DEF,
  parameter int unsigned THERM_TICKS = THERM_DEF,
  parameter int unsigned STARTUP_CYC = STARTUP_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shdn_pin_ni,
  input  logic           sw_shdn_i,
  input  logic [NCH-1:0] ch_en_i,
  input  logic [NCH-1:0] oc_det_i,
  input  logic           therm_raw_i,
  input  logic           tick_i,
  input  logic           flag_wr_i,
  input  logic [NCH-1:0] wr_fault_i,
  input  logic           wr_therm_i,
  output logic [NCH-1:0] stage_en_o,
  output logic [NCH-1:0] low_duty_o,
  output logic [NCH-1:0] fault_flag_o,
  output logic           therm_flag_o,
  output logic           reg_rst_o
);
  logic pin_s, active, ready, hot;

  amp_pin_sync i_sync (
    .clk_i, .rst_ni,
    .pin_i  (shdn_pin_ni),
    .pin_o  (pin_s),
    .fall_o (reg_rst_o)
  );

  assign active = pin_s & ~sw_shdn_i;

  amp_startup_timer #(.CYC(STARTUP_CYC)) i_timer (
    .clk_i, .rst_ni,
    .active_i (active),
    .ready_o  (ready)
  );

  amp_therm_deglitch #(.TICKS(THERM_TICKS)) i_therm (
    .clk_i, .rst_ni,
    .run_i  (pin_s),
    .tick_i (tick_i),
    .raw_i  (therm_raw_i),
    .hot_o  (hot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  therm_flag_o <= 1'b0;
    else if (!pin_s)              therm_flag_o <= 1'b0;
    else if (hot)                 therm_flag_o <= 1'b1;
    else if (flag_wr_i && !wr_therm_i) therm_flag_o <= 1'b0;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    amp_chan_fault i_fault (
      .clk_i, .rst_ni,
      .pin_i      (pin_s),
      .active_i   (active),
      .oc_i       (oc_det_i[c]),
      .wr_i       (flag_wr_i),
      .wr_bit_i   (wr_fault_i[c]),
      .flag_o     (fault_flag_o[c]),
      .low_duty_o (low_duty_o[c])
    );
    assign stage_en_o[c] = active & ready & ~hot & ch_en_i[c];
  end
endmodule

// File: rtl/amp_supervisor_chk.sv
module amp_supervisor_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           pin_s,
  input logic           sw_shdn_i,
  input logic           flag_wr_i,
  input logic [NCH-1:0] oc_det_i,
  input logic [NCH-1:0] stage_en_o,
  input logic [NCH-1:0] low_duty_o,
  input logic [NCH-1:0] fault_flag_o,
  input logic           reg_rst_o
);
  assert_one_clk_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_o |=> !reg_rst_o);

  assert_stage_needs_sw_on_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|stage_en_o) |-> !sw_shdn_i);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_fault_from_oc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fault_flag_o[c]) |-> $past(oc_det_i[c]));

    assert_low_duty_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (low_duty_o[c] && pin_s && !sw_shdn_i) |=> low_duty_o[c]);

    assert_flag_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_flag_o[c] && pin_s && !flag_wr_i) |=> fault_flag_o[c]);
  end
endmodule

bind amp_supervisor amp_supervisor_chk #(.NCH(NCH)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pin_s        (pin_s),
  .sw_shdn_i    (sw_shdn_i),
  .flag_wr_i    (flag_wr_i),
  .oc_det_i     (oc_det_i),
  .stage_en_o   (stage_en_o),
  .low_duty_o   (low_duty_o),
  .fault_flag_o (fault_flag_o),
  .reg_rst_o    (reg_rst_o)
);

// File: tb/test_amp_supervisor.sv
module test_amp_supervisor;
  localparam int unsigned NCH = 2;
  localparam int unsigned TT  = 16;
  localparam int unsigned SC  = 20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic shdn_pin_ni = 1'b0, sw_shdn_i = 1'b0;
  logic [NCH-1:0] ch_en_i = '1, oc_det_i = '0, wr_fault_i = '1;
  logic therm_raw_i = 1'b0, tick_i = 1'b1, flag_wr_i = 1'b0, wr_therm_i = 1'b1;
  logic [NCH-1:0] stage_en_o, low_duty_o, fault_flag_o;
  logic therm_flag_o, reg_rst_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  amp_supervisor #(.NCH(NCH), .THERM_TICKS(TT), .STARTUP_CYC(SC)) i_amp_supervisor (.*);

  task automatic step(int n);
    repeat (n) begin @(posedge clk_i); #5; end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic power_up();
    shdn_pin_ni = 1'b1;
    step(SC + 1);
    chk("R3 not yet", 8'(stage_en_o), 8'h0);
    step(1);
    chk("R3 enabled", 8'(stage_en_o), 8'h3);
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 stage", 8'(stage_en_o), 8'h0);
    chk("R1 low_duty", 8'(low_duty_o), 8'h0);
    chk("R1 flags", {5'd0, reg_rst_o, therm_flag_o, 1'b0} | 8'(fault_flag_o), 8'h0);
  endtask

  task automatic t_restart();
    shdn_pin_ni = 1'b1;
    step(SC / 2);
    shdn_pin_ni = 1'b0;
    step(3);
    chk("R3 aborted", 8'(stage_en_o), 8'h0);
    power_up();
  endtask

  task automatic t_ch_en();
    ch_en_i = 2'b01; #1;
    chk("R4 one channel", 8'(stage_en_o), 8'h1);
    ch_en_i = 2'b10; #1;
    chk("R4 other channel", 8'(stage_en_o), 8'h2);
    ch_en_i = 2'b11; #1;
  endtask

  task automatic t_fault();
    oc_det_i = 2'b01; step(1); oc_det_i = 2'b00;
    chk("R5 flag", 8'(fault_flag_o), 8'h1);
    chk("R5 low_duty", 8'(low_duty_o), 8'h1);
    chk("R5 stage kept", 8'(stage_en_o), 8'h3);
    flag_wr_i = 1'b1; wr_fault_i = 2'b11; step(1); flag_wr_i = 1'b0;
    chk("R7 write one keeps", 8'(fault_flag_o), 8'h1);
    flag_wr_i = 1'b1; wr_fault_i = 2'b10; step(1); flag_wr_i = 1'b0; wr_fault_i = 2'b11;
    chk("R7 write zero clears", 8'(fault_flag_o), 8'h0);
    chk("R6 low_duty after clear", 8'(low_duty_o), 8'h1);
    step(5);
    chk("R6 low_duty persists", 8'(low_duty_o), 8'h1);
  endtask

  task automatic t_sw_shdn();
    sw_shdn_i = 1'b1; step(1);
    chk("R11 low_duty cleared", 8'(low_duty_o), 8'h0);
    chk("R11 stage off", 8'(stage_en_o), 8'h0);
    chk("R11 no reg reset", 8'(reg_rst_o), 8'h0);
    sw_shdn_i = 1'b0;
    step(SC - 1);
    chk("R3 sw restart wait", 8'(stage_en_o), 8'h0);
    step(1);
    chk("R3 sw restart done", 8'(stage_en_o), 8'h3);
  endtask

  task automatic t_therm();
    therm_raw_i = 1'b1;
    step(TT - 1);
    chk("R8 before count", 8'(stage_en_o), 8'h3);
    step(1);
    chk("R9 gated", 8'(stage_en_o), 8'h0);
    step(1);
    chk("R9 flag set", 8'(therm_flag_o), 8'h1);
    therm_raw_i = 1'b0; step(1);
    chk("R9 recovered", 8'(stage_en_o), 8'h3);
    chk("R9 flag latched", 8'(therm_flag_o), 8'h1);
    flag_wr_i = 1'b1; wr_therm_i = 1'b1; step(1); flag_wr_i = 1'b0;
    chk("R10 write one keeps", 8'(therm_flag_o), 8'h1);
    flag_wr_i = 1'b1; wr_therm_i = 1'b0; step(1); flag_wr_i = 1'b0; wr_therm_i = 1'b1;
    chk("R10 write zero clears", 8'(therm_flag_o), 8'h0);
  endtask

  task automatic t_glitch();
    therm_raw_i = 1'b1; step(TT - 1);
    therm_raw_i = 1'b0; step(1);
    therm_raw_i = 1'b1; step(TT - 1);
    chk("R8 broken run", 8'(stage_en_o), 8'h3);
    therm_raw_i = 1'b0; step(1);
    tick_i = 1'b0; therm_raw_i = 1'b1; step(3 * TT);
    chk("R8 no ticks", 8'(stage_en_o), 8'h3);
    chk("R8 no flag", 8'(therm_flag_o), 8'h0);
    therm_raw_i = 1'b0; tick_i = 1'b1; step(1);
  endtask

  task automatic t_pin_down();
    oc_det_i = 2'b10; step(1); oc_det_i = 2'b00;
    chk("R5 ch1 flag", 8'(fault_flag_o), 8'h2);
    shdn_pin_ni = 1'b0;
    step(1);
    chk("R2 sync delay", 8'(reg_rst_o), 8'h0);
    step(1);
    chk("R2 pulse", 8'(reg_rst_o), 8'h1);
    step(1);
    chk("R2 pulse ends", 8'(reg_rst_o), 8'h0);
    chk("R2 flags cleared", 8'(fault_flag_o), 8'h0);
    chk("R6 pin clears low_duty", 8'(low_duty_o), 8'h0);
    chk("R1 stage off", 8'(stage_en_o), 8'h0);
    oc_det_i = 2'b11; step(1); oc_det_i = 2'b00;
    chk("R1 oc ignored in shutdown", 8'(fault_flag_o), 8'h0);
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    t_reset();
    t_restart();
    t_ch_en();
    t_fault();
    t_sw_shdn();
    t_therm();
    t_glitch();
    t_pin_down();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule